// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide, two-address register port of an eight-line interrupt controller. A host writes setup words and run-time command words through it, and reads back the pending, in-service and mask vectors. It holds the mask register, the vector base and the mode flags. It also turns each run-time command into a single-cycle strobe with a 3-bit argument, for the priority logic outside the block. The pending and in-service vectors, and the current winning line, come in from that external logic.

A low-address write with bit 4 set restarts setup. The block then takes the base word, the cascade word and, when requested, a mode word, all at the high address, and returns to normal operation. Other low-address writes are run-time commands. Bit 3 tells the read-control word apart from the end-of-interrupt and priority word, whose bits [7:5] hold an operation code. Reads have one cycle of latency. After poll is armed, one read returns the winning line and acknowledges it in the same access.

Top module: `intc_cmd_port`

## Requirements
- R1: After reset the mask, vector base, all mode flags and read data are zero, read-select points at pending, poll is disarmed, no strobe is active, and the block is in normal mode.
- R2: A low-address write with bit 4 set pulses `reinitStrb` in the same cycle and restarts setup. On the next cycle the mask, special-mask flag and read-select are zero. Nested and auto-EOI flags are cleared only when bit 0 of that word is 0.
- R3: The first high-address write after a restart loads `vecBase` with the written byte, its bits [2:0] forced to zero. The mask is not changed.
- R4: The second high-address write after a restart (the cascade word) changes no output. If bit 0 of the restart word was 0, the block is back in normal mode, so the next high-address write loads the mask.
- R5: When bit 0 of the restart word was 1, the third high-address write sets `nestedMode` from bit 4 and `autoEoi` from bit 1, and the block returns to normal mode.
- R6: In normal mode a high-address write loads the mask register. The mask changes at no other time except a restart.
- R7: A low-address write with bit 4 = 0 and bit 3 = 1 is a read-control word. Bit 2 arms poll. If bit 1 = 1, read-select takes bit 0 (1 = in-service, 0 = pending). If bit 6 = 1, `specialMask` takes bit 5. Fields whose enable bit is 0 stay unchanged.
- R8: A low-address write with bits 4 and 3 both 0 decodes code = bits [7:5], in the same cycle as the write. Code 1 pulses `eoiStrb`, 5 pulses `rotEoiStrb`, 3 pulses `specEoiStrb`, 7 pulses `rotSpecEoiStrb` and 6 pulses `setPrioStrb`, each with `cmdArg` = bits [2:0]. Code 0 clears `rotOnAutoEoi` and code 4 sets it. Code 2 has no effect.
- R9: One cycle after a read strobe with poll disarmed, `rdData` shows the in-service vector (address 0, read-select 1), the pending vector (address 0, read-select 0) or the mask (address 1). `rdData` holds between reads.
- R10: With poll armed, the next read returns the winning line zero-extended when `pollValid` is 1, otherwise 7. When `pollValid` is 1, that read pulses `pollAckStrb` with `cmdArg` = the line in the same cycle. The read disarms poll, so the following read is an ordinary one.
- R11: At most one command strobe is active in any cycle, and only in a cycle with a read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wrData | input | 8 | Write data |
| pendVec | input | 8 | Pending lines from priority logic |
| servVec | input | 8 | In-service lines from priority logic |
| pollValid | input | 1 | A line currently wins arbitration |
| pollLine | input | 3 | Winning line |
| rdData | output | 8 | Read data, one cycle after rdEn |
| maskReg | output | 8 | Line mask |
| vecBase | output | 8 | Vector base, low 3 bits zero |
| nestedMode | output | 1 | Special fully nested mode |
| autoEoi | output | 1 | Automatic end of interrupt |
| rotOnAutoEoi | output | 1 | Rotate priority on automatic EOI |
| specialMask | output | 1 | Special mask mode |
| reinitStrb | output | 1 | Setup restarted (clear rotation, edge state) |
| eoiStrb | output | 1 | Non-specific EOI |
| rotEoiStrb | output | 1 | Rotating non-specific EOI |
| specEoiStrb | output | 1 | Specific EOI on cmdArg |
| rotSpecEoiStrb | output | 1 | Rotating specific EOI on cmdArg |
| setPrioStrb | output | 1 | Set lowest priority to cmdArg |
| pollAckStrb | output | 1 | Poll read acknowledges cmdArg |
| cmdArg | output | 3 | Argument of the active strobe |

## Verification
The assertions take for granted that the host never issues a read and a write in the same cycle. A read and a write together would make the poll-disarm and the strobe exclusivity ambiguous. The stimulus drives at most one of the two strobes per cycle, in the directed sequences and in the random phase alike. `pollLine` is treated as meaningful only while `pollValid` is high, and the bench checks the acknowledge only in that case.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } setupSt_t;

  // register-update strobes from control to datapath
  typedef struct packed {
    logic reinit;
    logic keepModes;
    logic loadMask;
    logic loadBase;
    logic loadModes;
    logic rdCtl;
    logic setRot;
    logic clrRot;
  } regCtl_t;

  // run-time command strobes leaving the block
  typedef struct packed {
    logic nsEoi;
    logic rotEoi;
    logic specEoi;
    logic rotSpecEoi;
    logic setPrio;
  } opStrb_t;

endpackage

// File: rtl/intc_cmd_ctrl.sv
module intc_cmd_ctrl
  import intc_cmd_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    addr,
  input  logic [(1<<LINE_W)-1:0]  wrData,
  output regCtl_t                 regCtl,
  output opStrb_t                 opStrb
);
  localparam int DATA_W = 1 << LINE_W;

  setupSt_t state, stateNxt;
  logic     want4;
  logic     lowWr, highWr, isRestart, isRdCtl, isOpWord;
  logic [2:0] opCode;

  assign lowWr     = wrEn && !addr;
  assign highWr    = wrEn && addr;
  assign isRestart = lowWr && wrData[4];
  assign isRdCtl   = lowWr && !wrData[4] && wrData[3];
  assign isOpWord  = lowWr && !wrData[4] && !wrData[3];
  assign opCode    = wrData[DATA_W-1 -: 3];

  always_comb begin
    regCtl           = '0;
    regCtl.reinit    = isRestart;
    regCtl.keepModes = wrData[0];
    regCtl.rdCtl     = isRdCtl;
    if (highWr) begin
      unique case (state)
        ST_RUN:  regCtl.loadMask  = 1'b1;
        ST_BASE: regCtl.loadBase  = 1'b1;
        ST_MODE: regCtl.loadModes = 1'b1;
        default: ;
      endcase
    end
    opStrb = '0;
    if (isOpWord) begin
      unique case (opCode)
        3'd0: regCtl.clrRot      = 1'b1;
        3'd1: opStrb.nsEoi       = 1'b1;
        3'd3: opStrb.specEoi     = 1'b1;
        3'd4: regCtl.setRot      = 1'b1;
        3'd5: opStrb.rotEoi      = 1'b1;
        3'd6: opStrb.setPrio     = 1'b1;
        3'd7: opStrb.rotSpecEoi  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    stateNxt = state;
    if (isRestart) begin
      stateNxt = ST_BASE;
    end else if (highWr) begin
      unique case (state)
        ST_BASE: stateNxt = ST_CASC;
        ST_CASC: stateNxt = want4 ? ST_MODE : ST_RUN;
        ST_MODE: stateNxt = ST_RUN;
        default: stateNxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      want4 <= 1'b0;
    end else begin
      state <= stateNxt;
      if (isRestart) want4 <= wrData[0];
    end
  end

endmodule

// File: rtl/intc_cmd_regs.sv
module intc_cmd_regs
  import intc_cmd_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regCtl_t                 regCtl,
  input  logic                    rdEn,
  input  logic                    addr,
  input  logic [(1<<LINE_W)-1:0]  wrData,
  input  logic [(1<<LINE_W)-1:0]  pendVec,
  input  logic [(1<<LINE_W)-1:0]  servVec,
  input  logic                    pollValid,
  input  logic [LINE_W-1:0]       pollLine,
  output logic [(1<<LINE_W)-1:0]  rdData,
  output logic [(1<<LINE_W)-1:0]  maskReg,
  output logic [(1<<LINE_W)-1:0]  vecBase,
  output logic                    nestedMode,
  output logic                    autoEoi,
  output logic                    rotOnAutoEoi,
  output logic                    specialMask,
  output logic                    pollAck
);
  localparam int DATA_W = 1 << LINE_W;
  localparam logic [DATA_W-1:0] NO_WINNER = DATA_W'(DATA_W - 1);

  logic selServ;
  logic pollArmed;
  logic [DATA_W-1:0] rdNxt;

  assign pollAck = rdEn && pollArmed && pollValid;

  always_comb begin
    if (pollArmed)
      rdNxt = pollValid ? DATA_W'(pollLine) : NO_WINNER;
    else if (addr)
      rdNxt = maskReg;
    else
      rdNxt = selServ ? servVec : pendVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg      <= '0;
      vecBase      <= '0;
      nestedMode   <= 1'b0;
      autoEoi      <= 1'b0;
      rotOnAutoEoi <= 1'b0;
      specialMask  <= 1'b0;
      selServ      <= 1'b0;
      pollArmed    <= 1'b0;
      rdData       <= '0;
    end else begin
      if (regCtl.reinit) begin
        maskReg     <= '0;
        specialMask <= 1'b0;
        selServ     <= 1'b0;
        if (!regCtl.keepModes) begin
          nestedMode <= 1'b0;
          autoEoi    <= 1'b0;
        end
      end
      if (regCtl.loadMask)  maskReg <= wrData;
      if (regCtl.loadBase)  vecBase <= {wrData[DATA_W-1:LINE_W], LINE_W'(0)};
      if (regCtl.loadModes) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (regCtl.rdCtl) begin
        if (wrData[2]) pollArmed   <= 1'b1;
        if (wrData[1]) selServ     <= wrData[0];
        if (wrData[6]) specialMask <= wrData[5];
      end
      if (regCtl.setRot) rotOnAutoEoi <= 1'b1;
      if (regCtl.clrRot) rotOnAutoEoi <= 1'b0;
      if (rdEn) begin
        rdData    <= rdNxt;
        pollArmed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/intc_cmd_port.sv
module intc_cmd_port
  import intc_cmd_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic                    addr,
  input  logic [(1<<LINE_W)-1:0]  wrData,
  input  logic [(1<<LINE_W)-1:0]  pendVec,
  input  logic [(1<<LINE_W)-1:0]  servVec,
  input  logic                    pollValid,
  input  logic [LINE_W-1:0]       pollLine,
  output logic [(1<<LINE_W)-1:0]  rdData,
  output logic [(1<<LINE_W)-1:0]  maskReg,
  output logic [(1<<LINE_W)-1:0]  vecBase,
  output logic                    nestedMode,
  output logic                    autoEoi,
  output logic                    rotOnAutoEoi,
  output logic                    specialMask,
  output logic                    reinitStrb,
  output logic                    eoiStrb,
  output logic                    rotEoiStrb,
  output logic                    specEoiStrb,
  output logic                    rotSpecEoiStrb,
  output logic                    setPrioStrb,
  output logic                    pollAckStrb,
  output logic [LINE_W-1:0]       cmdArg
);
  regCtl_t regCtl;
  opStrb_t opStrb;

  intc_cmd_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .regCtl (regCtl),
    .opStrb (opStrb)
  );

  intc_cmd_regs #(.LINE_W(LINE_W)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .regCtl       (regCtl),
    .rdEn         (rdEn),
    .addr         (addr),
    .wrData       (wrData),
    .pendVec      (pendVec),
    .servVec      (servVec),
    .pollValid    (pollValid),
    .pollLine     (pollLine),
    .rdData       (rdData),
    .maskReg      (maskReg),
    .vecBase      (vecBase),
    .nestedMode   (nestedMode),
    .autoEoi      (autoEoi),
    .rotOnAutoEoi (rotOnAutoEoi),
    .specialMask  (specialMask),
    .pollAck      (pollAckStrb)
  );

  assign reinitStrb     = regCtl.reinit;
  assign eoiStrb        = opStrb.nsEoi;
  assign rotEoiStrb     = opStrb.rotEoi;
  assign specEoiStrb    = opStrb.specEoi;
  assign rotSpecEoiStrb = opStrb.rotSpecEoi;
  assign setPrioStrb    = opStrb.setPrio;
  assign cmdArg         = pollAckStrb ? pollLine : wrData[LINE_W-1:0];

endmodule

// File: rtl/intc_cmd_port_chk.sv
module intc_cmd_port_chk #(
  parameter int LINE_W = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic                    addr,
  input logic [(1<<LINE_W)-1:0]  wrData,
  input logic                    pollValid,
  input logic [(1<<LINE_W)-1:0]  rdData,
  input logic [(1<<LINE_W)-1:0]  maskReg,
  input logic                    reinitStrb,
  input logic                    eoiStrb,
  input logic                    rotEoiStrb,
  input logic                    specEoiStrb,
  input logic                    rotSpecEoiStrb,
  input logic                    setPrioStrb,
  input logic                    pollAckStrb
);
  logic [6:0] strbs;
  assign strbs = {reinitStrb, eoiStrb, rotEoiStrb, specEoiStrb,
                  rotSpecEoiStrb, setPrioStrb, pollAckStrb};

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strbs));

  assert_strobe_needs_access_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strbs != '0) |-> (wrEn || rdEn));

  assert_restart_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    reinitStrb |-> (wrEn && !addr && wrData[4]));

  assert_restart_clears_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    reinitStrb |=> (maskReg == '0));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(maskReg));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_poll_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    pollAckStrb |-> (rdEn && pollValid));

endmodule

bind intc_cmd_port intc_cmd_port_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/intc_cmd_port_tb.sv
module intc_cmd_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0, pendVec = '0, servVec = '0;
  logic pollValid = 1'b0;
  logic [2:0] pollLine = '0;
  logic [7:0] rdData, maskReg, vecBase;
  logic nestedMode, autoEoi, rotOnAutoEoi, specialMask;
  logic reinitStrb, eoiStrb, rotEoiStrb, specEoiStrb, rotSpecEoiStrb, setPrioStrb, pollAckStrb;
  logic [2:0] cmdArg;

  int testsRun = 0, testsFailed = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  intc_cmd_port u_dut (.*);

  // behavioural reference model
  int mMask, mBase, mRd, mStage;
  bit mNested, mAeoi, mRot, mSmask, mSel, mPoll, mWant4;

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mBase = 0; mRd = 0; mStage = 0;
      mNested = 0; mAeoi = 0; mRot = 0; mSmask = 0; mSel = 0; mPoll = 0; mWant4 = 0;
    end else begin
      if (wrEn && !addr) begin
        if (wrData[4]) begin
          mWant4 = wrData[0]; mMask = 0; mSmask = 0; mSel = 0; mStage = 1;
          if (!wrData[0]) begin mNested = 0; mAeoi = 0; end
        end else if (wrData[3]) begin
          if (wrData[2]) mPoll = 1;
          if (wrData[1]) mSel = wrData[0];
          if (wrData[6]) mSmask = wrData[5];
        end else begin
          if (wrData[7:5] == 3'd0) mRot = 0;
          if (wrData[7:5] == 3'd4) mRot = 1;
        end
      end else if (wrEn && addr) begin
        case (mStage)
          0: mMask = wrData;
          1: begin mBase = wrData & 8'hF8; mStage = 2; end
          2: mStage = mWant4 ? 3 : 0;
          default: begin mNested = wrData[4]; mAeoi = wrData[1]; mStage = 0; end
        endcase
      end
      if (rdEn) begin
        if (mPoll) mRd = pollValid ? int'(pollLine) : 7;
        else if (addr) mRd = mMask;
        else mRd = mSel ? servVec : pendVec;
        mPoll = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, in the low phase
  always @(negedge clk) begin
    #2;
    if (rstN && !doneFlag) begin
      bit opw;
      int code;
      opw  = wrEn && !addr && !wrData[4] && !wrData[3];
      code = wrData[7:5];
      chk("R6 mask", maskReg, mMask);
      chk("R3 base", vecBase, mBase);
      chk("R5 nested", nestedMode, mNested);
      chk("R5 autoEoi", autoEoi, mAeoi);
      chk("R8 rotOnAutoEoi", rotOnAutoEoi, mRot);
      chk("R7 specialMask", specialMask, mSmask);
      chk("R9 rdData", rdData, mRd);
      chk("R2 reinitStrb", reinitStrb, wrEn && !addr && wrData[4]);
      chk("R8 eoiStrb", eoiStrb, opw && code == 1);
      chk("R8 rotEoiStrb", rotEoiStrb, opw && code == 5);
      chk("R8 specEoiStrb", specEoiStrb, opw && code == 3);
      chk("R8 rotSpecEoiStrb", rotSpecEoiStrb, opw && code == 7);
      chk("R8 setPrioStrb", setPrioStrb, opw && code == 6);
      chk("R10 pollAckStrb", pollAckStrb, rdEn && mPoll && pollValid);
      if (rdEn && mPoll && pollValid) chk("R10 cmdArg", cmdArg, pollLine);
      else if (opw && code inside {1, 3, 5, 6, 7}) chk("R8 cmdArg", cmdArg, wrData[2:0]);
      chk("R11 strobe count",
          $countones({reinitStrb, eoiStrb, rotEoiStrb, specEoiStrb,
                      rotSpecEoiStrb, setPrioStrb, pollAckStrb}) <= 1, 1);
    end
  end

  task automatic step(bit w, bit r, bit a, logic [7:0] d);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
  endtask

  initial begin
    #800000;
    if (!doneFlag) begin
      doneFlag = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #2;
    chk("R1 reset mask", maskReg, 0);
    chk("R1 reset base", vecBase, 0);
    chk("R1 reset flags", {nestedMode, autoEoi, rotOnAutoEoi, specialMask}, 0);
    chk("R1 reset rdData", rdData, 0);
    @(negedge clk);
    pendVec = 8'h3C; servVec = 8'h81;
    step(0, 1, 0, 0);                 // R1 select pending
    step(0, 0, 0, 0);
    #2 chk("R1 read-select pending", rdData, 8'h3C);
    @(negedge clk);
    step(1, 0, 0, 8'h11);             // R2 restart with mode word
    step(1, 0, 1, 8'h47);             // R3 base
    step(1, 0, 1, 8'h04);             // R4 cascade
    step(1, 0, 1, 8'h12);             // R5 mode word
    step(1, 0, 1, 8'hA5);             // R6 mask
    step(0, 1, 1, 0);
    step(1, 0, 0, 8'h0B);             // R7 select in-service
    step(0, 1, 0, 0);
    step(1, 0, 0, 8'h68);             // R7 special mask on
    step(1, 0, 0, 8'h0C);             // R10 arm poll
    pollValid = 1; pollLine = 3'd5;
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);                 // R10 ordinary read after poll
    step(1, 0, 0, 8'h0C);
    pollValid = 0;
    step(0, 1, 0, 0);                 // R10 no winner -> 7
    for (int c = 0; c < 8; c++) step(1, 0, 0, {c[2:0], 5'b00110});
    step(1, 0, 0, 8'h10);             // R2 restart without mode word
    step(1, 0, 1, 8'hFF);
    step(1, 0, 1, 8'h00);             // R4 cascade ignored
    step(1, 0, 1, 8'h5A);             // R4 back to normal: mask load
    #2 chk("R4 mask after short setup", maskReg, 8'h5A);
    chk("R4 modes cleared", {nestedMode, autoEoi}, 0);
    @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [7:0] d;
      k = $urandom_range(0, 9);
      d = 8'($urandom);
      pendVec = 8'($urandom); servVec = 8'($urandom);
      pollValid = 1'($urandom); pollLine = 3'($urandom);
      if (k < 2) step(1, 0, 0, d & 8'hEF);
      else if (k == 2 && ($urandom_range(0, 3) == 0)) step(1, 0, 0, d | 8'h10);
      else if (k < 5) step(1, 0, 1, d);
      else if (k < 7) step(0, 1, 1'($urandom), 0);
      else if (k == 7) step(1, 0, 0, (d & 8'hEB) | 8'h0C);
      else step(0, 0, 0, d);
    end
    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule